// File: doc/BRIEF.md
# Sync-Locked On-Screen-Display Overlay Generator

This block lays a low-resolution graphic over a running video signal. It is clocked by the pixel clock of the incoming video and watches that video's horizontal and vertical sync pulses. From these it rebuilds the column and line position of every pixel. Inside a programmable window it produces, for each video pixel, a select bit for an external video switch and a reduced-depth colour. The switch then shows either this colour or the original picture.

Overlay pixels are stored as packed 8-bit words in a line store with two banks. Each word is stretched over a square of video pixels: four columns wide, and repeated on four consecutive lines. A whole row group of four lines is shown from one bank. Meanwhile a host fills the other bank through a valid/ready write port. The banks trade places when the row group ends, and the block reports this with a one-cycle pulse and a bank flag. The write port is the only data stream into the block. A write is taken on a clock edge where both `wr_valid` and `wr_ready` are high. When `wr_ready` is low, the host must hold valid, address and data unchanged until the write is taken.

Top module: `osd_sync_overlay`

## Requirements
- R1: While `rst_n` is low, `mux_sel`, `ovl_r`, `ovl_g`, `ovl_b`, `swap_pulse` and `rd_bank` are 0, and `wr_ready` is 1.
- R2: The active level of each sync input is chosen by its polarity pin (1 = active high, 0 = active low). Each sync input passes two synchroniser flops. Suppose the horizontal sync input becomes active before clock edge E0. Then column k of the new line is visible on the overlay outputs after edge E(3+k).
- R3: An active vertical-sync edge puts the line counter in a state before line 0. Each active horizontal-sync edge then advances it, so the first line after vertical sync is line 0.
- R4: A pixel lies in the window when two conditions hold. Its line is in [Y, Y+4·G). Its column is in [X, X+4·W). Here W is `cfg_words`, limited to the line-store depth. Outside the window, `mux_sel` and all colour outputs are 0.
- R5: Inside the window, column c shows word (c−X)/4 of the displayed bank. `mux_sel` is bit 7. `ovl_r` is bits 6:5, `ovl_g` is bits 4:2 and `ovl_b` is bits 1:0. Colours are driven whatever the value of bit 7.
- R6: While the vertical sync is active, `mux_sel` and the colours are 0, even on lines inside the window.
- R7: X, Y, W and G are sampled only at the active vertical-sync edge. A change made during a frame has no effect until the next one.
- R8: A row group ends when line Y+4n+3 finishes, at the active horizontal-sync edge that closes that line. At that edge, `rd_bank` toggles and the new bank is shown from column 0 of the next line. `swap_pulse` is high for exactly the one cycle after that edge.
- R9: An accepted write stores `wr_data` at `wr_addr` of the bank that is not displayed. What is shown from the displayed bank does not change.
- R10: `wr_ready` is low only in the cycle just before a swap edge, and a write offered in that cycle is not stored. In every other cycle it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video pixel clock |
| rst_n | input | 1 | Active-low reset |
| hsync_raw | input | 1 | Incoming horizontal sync, asynchronous |
| vsync_raw | input | 1 | Incoming vertical sync, asynchronous |
| hs_active_high | input | 1 | Horizontal sync polarity (1 = active high) |
| vs_active_high | input | 1 | Vertical sync polarity (1 = active high) |
| cfg_col | input | PIX_W | Window first column X |
| cfg_line | input | LINE_W | Window first line Y |
| cfg_words | input | WORDS_W | Window width in words W |
| cfg_groups | input | GRP_W | Window height in row groups G |
| wr_valid | input | 1 | Host write offered |
| wr_ready | output | 1 | Host write can be taken this cycle |
| wr_addr | input | IDX_W | Word address in the back bank |
| wr_data | input | 8 | Packed overlay word |
| mux_sel | output | 1 | Select overlay (1) or pass-through video (0) |
| ovl_r | output | 2 | Overlay red |
| ovl_g | output | 3 | Overlay green |
| ovl_b | output | 2 | Overlay blue |
| swap_pulse | output | 1 | One-cycle pulse after a bank swap |
| rd_bank | output | 1 | Bank currently displayed |

## Verification
Every cycle of every line is compared pixel by pixel with a model of the window and the bank contents. The first runs use fixed windows. One window starts at line 0 and one starts later, which shows whether lines are counted from the right origin. One width exceeds the store depth, which tests the clamp. One frame runs with active-low sync, which tests the polarity pins and the three-cycle latency. One frame keeps vertical sync active over lines inside the window, which separates blanking from the window test. In another frame the window inputs change halfway through, which shows that they are sampled only at the frame edge. Random windows, random polarities and random words then check word selection and the four-line replay. At every swap edge the bench offers a write of 0xFF to word 0. Taking that write would corrupt the bank about to be shown, so the back-pressure rule can be seen at the pixel outputs.

// File: rtl/osd_pkg.sv
package osd_pkg;
  // Packed overlay word; bit positions are decoded directly onto the outputs.
  typedef struct packed {
    logic       sel;
    logic [1:0] red;
    logic [2:0] green;
    logic [1:0] blue;
  } ovl_word_t;

  localparam int unsigned OVL_WORD_W = $bits(ovl_word_t);
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/osd_sync_in.sv
module osd_sync_in #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic active_high,
  output logic act,
  output logic rise
);
  // Polarity folded in ahead of the flops so a polarity change moving with
  // the idle level of the pin never produces a false edge.
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], raw ~^ active_high};
  end

  assign act  = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/osd_raster.sv
module osd_raster #(
  parameter int unsigned PIX_W      = 12,
  parameter int unsigned LINE_W     = 12,
  parameter int unsigned LINE_WORDS = 64,
  parameter int unsigned GRP_W      = 8,
  parameter int unsigned SCALE_LOG2 = 2,
  localparam int unsigned WORDS_W   = $clog2(LINE_WORDS + 1),
  localparam int unsigned IDX_W     = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_rise,
  input  logic              vs_rise,
  input  logic [PIX_W-1:0]  cfg_col,
  input  logic [LINE_W-1:0] cfg_line,
  input  logic [WORDS_W-1:0] cfg_words,
  input  logic [GRP_W-1:0]  cfg_groups,
  output logic              in_win,
  output logic [IDX_W-1:0]  word_idx,
  output logic              rd_bank,
  output logic              swap_now,
  output logic              swap_pulse
);
  localparam logic [WORDS_W-1:0] MAX_WORDS = WORDS_W'(LINE_WORDS);
  localparam logic [PIX_W-1:0]   PIX_MAX   = '1;

  logic [PIX_W-1:0]   pix_cnt;
  logic [LINE_W-1:0]  line_cnt;
  logic [PIX_W-1:0]   win_col;
  logic [LINE_W-1:0]  win_line;
  logic [WORDS_W-1:0] win_words;
  logic [GRP_W-1:0]   win_groups;

  // R2: column counter restarts on the horizontal edge and saturates.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pix_cnt <= '0;
    else if (hs_rise)          pix_cnt <= '0;
    else if (pix_cnt != PIX_MAX) pix_cnt <= pix_cnt + PIX_W'(1);
  end

  // R3: all-ones marks "before line 0" after a vertical edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       line_cnt <= '1;
    else if (vs_rise) line_cnt <= '1;
    else if (hs_rise) line_cnt <= line_cnt + LINE_W'(1);
  end

  // R7: window captured once per frame.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_col    <= '0;
      win_line   <= '0;
      win_words  <= '0;
      win_groups <= '0;
    end else if (vs_rise) begin
      win_col    <= cfg_col;
      win_line   <= cfg_line;
      win_words  <= (cfg_words > MAX_WORDS) ? MAX_WORDS : cfg_words;
      win_groups <= cfg_groups;
    end
  end

  logic [PIX_W-1:0]  rel_col;
  logic [LINE_W-1:0] rel_line;
  logic [PIX_W:0]    col_span;
  logic [LINE_W:0]   row_span;
  logic              in_cols, in_rows, last_phase;

  assign rel_col  = pix_cnt - win_col;
  assign rel_line = line_cnt - win_line;
  assign col_span = (PIX_W+1)'(win_words) << SCALE_LOG2;
  assign row_span = (LINE_W+1)'(win_groups) << SCALE_LOG2;

  assign in_cols    = (pix_cnt >= win_col) && ({1'b0, rel_col} < col_span);
  assign in_rows    = (line_cnt >= win_line) && ({1'b0, rel_line} < row_span);
  assign last_phase = &rel_line[SCALE_LOG2-1:0];

  assign in_win   = in_cols && in_rows;
  assign word_idx = rel_col[SCALE_LOG2 +: IDX_W];

  // R8: swap decided by the edge that closes the last line of a group.
  assign swap_now = hs_rise && in_rows && last_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bank    <= 1'b0;
      swap_pulse <= 1'b0;
    end else begin
      swap_pulse <= swap_now;
      if (swap_now) rd_bank <= ~rd_bank;
    end
  end

  // R2
  pix_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_rise |=> pix_cnt == '0);

  // R3
  line_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> line_cnt == '1);

  // R8
  bank_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_pulse |-> rd_bank != $past(rd_bank));

  // R8
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_pulse |-> rd_bank == $past(rd_bank));

  // R2
  pix_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_cnt == PIX_MAX && !hs_rise) |=> pix_cnt == PIX_MAX);
endmodule

// File: rtl/osd_line_buf.sv
module osd_line_buf #(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_bank,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] bank_mem [2][DEPTH];

  // R9: writes land only in the bank named by the caller.
  always_ff @(posedge clk) begin
    if (wr_en) bank_mem[wr_bank][wr_addr] <= wr_data;
  end

  assign rd_data = bank_mem[rd_bank][rd_idx];
endmodule

// File: rtl/osd_sync_overlay.sv
module osd_sync_overlay
  import osd_pkg::*;
#(
  parameter int unsigned PIX_W      = 12,
  parameter int unsigned LINE_W     = 12,
  parameter int unsigned LINE_WORDS = 64,
  parameter int unsigned GRP_W      = 8,
  parameter int unsigned SCALE_LOG2 = 2,
  localparam int unsigned WORDS_W   = $clog2(LINE_WORDS + 1),
  localparam int unsigned IDX_W     = $clog2(LINE_WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hsync_raw,
  input  logic               vsync_raw,
  input  logic               hs_active_high,
  input  logic               vs_active_high,
  input  logic [PIX_W-1:0]   cfg_col,
  input  logic [LINE_W-1:0]  cfg_line,
  input  logic [WORDS_W-1:0] cfg_words,
  input  logic [GRP_W-1:0]   cfg_groups,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [IDX_W-1:0]   wr_addr,
  input  logic [OVL_WORD_W-1:0] wr_data,
  output logic               mux_sel,
  output logic [1:0]         ovl_r,
  output logic [2:0]         ovl_g,
  output logic [1:0]         ovl_b,
  output logic               swap_pulse,
  output logic               rd_bank
);
  logic hs_act, hs_rise, vs_act, vs_rise;
  logic in_win, swap_now;
  logic [IDX_W-1:0] word_idx;
  logic [OVL_WORD_W-1:0] rd_word;
  ovl_word_t out_q;

  osd_sync_in #(.STAGES(SYNC_STAGES)) u_hsync (
    .clk(clk), .rst_n(rst_n), .raw(hsync_raw), .active_high(hs_active_high),
    .act(hs_act), .rise(hs_rise));

  osd_sync_in #(.STAGES(SYNC_STAGES)) u_vsync (
    .clk(clk), .rst_n(rst_n), .raw(vsync_raw), .active_high(vs_active_high),
    .act(vs_act), .rise(vs_rise));

  osd_raster #(
    .PIX_W(PIX_W), .LINE_W(LINE_W), .LINE_WORDS(LINE_WORDS),
    .GRP_W(GRP_W), .SCALE_LOG2(SCALE_LOG2)
  ) u_raster (
    .clk(clk), .rst_n(rst_n), .hs_rise(hs_rise), .vs_rise(vs_rise),
    .cfg_col(cfg_col), .cfg_line(cfg_line), .cfg_words(cfg_words),
    .cfg_groups(cfg_groups), .in_win(in_win), .word_idx(word_idx),
    .rd_bank(rd_bank), .swap_now(swap_now), .swap_pulse(swap_pulse));

  // R10: hold off the host in the one cycle the banks change roles.
  assign wr_ready = ~swap_now;

  osd_line_buf #(.WORD_W(OVL_WORD_W), .DEPTH(LINE_WORDS)) u_lbuf (
    .clk(clk), .wr_en(wr_valid & wr_ready), .wr_bank(~rd_bank),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_bank(rd_bank),
    .rd_idx(word_idx), .rd_data(rd_word));

  // R4 R5 R6: one output register; blanking and window force pass-through.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          out_q <= '0;
    else if (in_win && !hs_act && !vs_act) out_q <= ovl_word_t'(rd_word);
    else                                 out_q <= '0;
  end

  assign mux_sel = out_q.sel;
  assign ovl_r   = out_q.red;
  assign ovl_g   = out_q.green;
  assign ovl_b   = out_q.blue;

  // R6
  vs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(vs_act) |-> (!mux_sel && ovl_r == '0 && ovl_g == '0 && ovl_b == '0));

  // R10
  swap_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |=> swap_pulse);
endmodule

// File: tb/osd_sync_overlay_bench.sv
module osd_sync_overlay_bench;
  localparam int LW  = 8;
  localparam int LEN = 48;
  localparam int HSW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync_raw = 1'b0, vsync_raw = 1'b0;
  logic hs_pol = 1'b1, vs_pol = 1'b1;
  logic [11:0] cfg_col = '0, cfg_line = '0;
  logic [3:0]  cfg_words = '0;
  logic [7:0]  cfg_groups = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        mux_sel, swap_pulse, rd_bank;
  logic [1:0]  ovl_r, ovl_b;
  logic [2:0]  ovl_g;

  osd_sync_overlay #(.LINE_WORDS(LW)) u_osd_sync_overlay (
    .clk(clk), .rst_n(rst_n), .hsync_raw(hsync_raw), .vsync_raw(vsync_raw),
    .hs_active_high(hs_pol), .vs_active_high(vs_pol),
    .cfg_col(cfg_col), .cfg_line(cfg_line), .cfg_words(cfg_words),
    .cfg_groups(cfg_groups), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .mux_sel(mux_sel),
    .ovl_r(ovl_r), .ovl_g(ovl_g), .ovl_b(ovl_b),
    .swap_pulse(swap_pulse), .rd_bank(rd_bank));

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int mX, mY, mW, mG, mline;
  bit mvs, mbank;
  string ftag = "";
  logic [7:0] shadow [2][LW];

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp, string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic logic [8:0] expect_px(int line, int p);
    if (mvs) return 9'd0;
    if (line < mY || line >= mY + 4 * mG) return 9'd0;
    if (p < mX || p >= mX + 4 * mW) return 9'd0;
    return {1'b1, shadow[mbank][(p - mX) / 4]};
  endfunction

  function automatic bit group_end(int line);
    return line >= mY && line < mY + 4 * mG && ((line - mY) % 4) == 3;
  endfunction

  function automatic logic [7:0] outs();
    return {mux_sel, ovl_r, ovl_g, ovl_b};
  endfunction

  // R9: refill the back bank between lines.
  task automatic wr_batch();
    for (int a = 0; a < LW; a++) begin
      @(negedge clk);
      check("R10", wr_ready, 1, "ready outside swap");
      wr_valid = 1'b1;
      wr_addr  = 3'(a);
      wr_data  = 8'($urandom);
      shadow[!mbank][a] = wr_data;
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic run_line();
    bit sw;
    logic [8:0] e;
    string tg;
    sw = group_end(mline);
    mline = mline + 1;
    if (sw) mbank = !mbank;
    hsync_raw = hs_pol;
    for (int j = 0; j < LEN; j++) begin
      @(negedge clk);
      if (j + 1 == HSW) hsync_raw = !hs_pol;
      check("R8", swap_pulse, (j == 2 && sw), "swap pulse");
      if (j == 1) begin
        check("R10", wr_ready, !sw, "ready at swap edge");
        if (sw) begin wr_valid = 1'b1; wr_addr = 3'd0; wr_data = 8'hFF; end
      end
      if (j == 2) begin
        wr_valid = 1'b0;
        check("R8", rd_bank, mbank, "displayed bank");
      end
      if (j < 3) check("R4", outs(), 0, "line start");
      else begin
        e = expect_px(mline, j - 3);
        if (ftag != "")  tg = ftag;
        else if (mvs)    tg = "R6";
        else if (e[8])   tg = "R5";
        else             tg = "R4";
        check(tg, outs(), e[7:0], $sformatf("line %0d col %0d", mline, j - 3));
      end
    end
    wr_batch();
  endtask

  task automatic frame(int x, int y, int w, int g, bit hold);
    cfg_col = 12'(x); cfg_line = 12'(y); cfg_words = 4'(w); cfg_groups = 8'(g);
    vsync_raw = vs_pol;
    repeat (6) @(negedge clk);
    mX = x; mY = y; mW = (w > LW) ? LW : w; mG = g; mline = -1; mvs = hold;
    if (!hold) vsync_raw = !vs_pol;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_pol(bit p);
    @(negedge clk);
    hs_pol = p; vs_pol = p; hsync_raw = !p; vsync_raw = !p;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    mbank = 0; mvs = 0; mline = -1; mX = 0; mY = 0; mW = 0; mG = 0;
    repeat (3) @(negedge clk);
    // R1
    check("R1", outs(), 0, "reset outputs");
    check("R1", swap_pulse, 0, "reset swap pulse");
    check("R1", rd_bank, 0, "reset bank");
    check("R1", wr_ready, 1, "reset ready");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Priming frame: empty window, swaps fill both banks (R4 zero width).
    frame(0, 0, 0, 1, 0);
    repeat (5) run_line();

    // R3: window starts on line 1.
    ftag = "R3";
    frame(8, 1, 4, 2, 0);
    repeat (11) run_line();

    // R2: active-low syncs, width clamped to the store depth (R4).
    ftag = "R2";
    set_pol(0);
    frame(12, 0, 10, 1, 0);
    repeat (6) run_line();
    set_pol(1);

    // R6: vertical sync held over window lines.
    ftag = "";
    frame(8, 0, 3, 2, 1);
    repeat (3) run_line();
    vsync_raw = !vs_pol;
    repeat (4) @(negedge clk);
    mvs = 0;
    repeat (7) run_line();

    // R7: mid-frame window change ignored.
    frame(6, 2, 5, 2, 0);
    repeat (4) run_line();
    cfg_col = 12'd20; cfg_line = 12'd0; cfg_words = 4'd1; cfg_groups = 8'd3;
    ftag = "R7";
    repeat (8) run_line();

    // R9: random windows, words and polarities.
    ftag = "R9";
    for (int f = 0; f < 5; f++) begin
      int x, w, y, g;
      set_pol(1'($urandom));
      x = 6 + int'($urandom % 7);
      w = int'($urandom % ((44 - x) / 4 + 1));
      if (w > LW) w = LW;
      y = int'($urandom % 4);
      g = 1 + int'($urandom % 3);
      frame(x, y, w, g, 0);
      repeat (y + 4 * g + 2) run_line();
    end

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule